// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block is a synchronous static memory with a two-stage pipeline. Every rising clock edge it accepts one command, either a read or a write, and it needs no idle cycle when the direction changes. All command inputs are registered at the edge. Those inputs are the address, the read/write select, three chip selects, four byte-lane write enables and a load/advance strobe. Write data follows its address by two edges, and read data is driven by the same two edges later. Because of this, a stream that mixes reads and writes keeps the data path busy on every cycle.

A load cycle captures a fresh address, direction and chip-select state. A cycle with the load strobe inactive is an advance cycle. It keeps the loaded direction and selection and steps a two-bit beat counter, which wraps modulo four over the lowest address bits. The upper address bits do not change during a burst.

The read data bus is gated by an output enable. This enable acts combinationally and does not wait for a clock edge. A deselected load, or an advance that follows one, leaves the bus undriven.

Top module: `pipe_burst_sram`

## Requirements
- R1: After reset, and on every cycle in which `dout_en` is 0, `dout` is all zeros. Immediately after reset, `dout_en` is 0.
- R2: A selected read command registered at rising edge k drives the stored word on `dout` with `dout_en`=1, from edge k+2 until edge k+3. This holds while `oe_n` is 0. The read/write input encoding is `rw`=1 for read and `rw`=0 for write.
- R3: The write data for a selected write command registered at edge k is taken from `din` at edge k+2. During the cycle that follows such a write, the bus is not driven.
- R4: When `ld_n`=1 at an edge, the beat address becomes the previous beat plus one, modulo 4, in the two lowest address bits. The upper address bits keep their loaded value, and the `addr` input has no effect.
- R5: The `rw` input has no effect on an advance cycle (`ld_n`=1). The burst keeps the direction set at its load cycle.
- R6: A load cycle selects the device only when `cs_a_n`=0, `cs_b_n`=0 and `cs_c`=1. The chip selects are ignored on advance cycles. A deselected command neither writes the array nor drives the bus.
- R7: Byte-lane write enable `bwe_n[i]` is active low and belongs to the command cycle. It governs bits `[i*LANE_W +: LANE_W]` of the write data. A lane whose enable is 1 keeps its previous stored value.
- R8: When `oe_n`=1, `dout_en` is 0. `oe_n` gates the bus combinationally within the same cycle, with no clock edge involved.
- R9: A read issued on the cycle right after a write to the same word returns the new data, merged per lane with the old contents. Reads and writes may alternate on every cycle.
- R10: Advance cycles that follow a deselected load stay deselected, whatever the chip selects are on those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state |
| ld_n | input | 1 | 0 = load new address, 1 = advance burst |
| rw | input | 1 | 1 = read, 0 = write (used on load cycles only) |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b_n | input | 1 | Chip select, active low |
| cs_c | input | 1 | Chip select, active high |
| addr | input | ADDR_W | Word address |
| bwe_n | input | LANES | Byte-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data, two edges after its address |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | High when the block drives `dout` |

## Verification
The bound checker keeps its own record of chip selection and direction, built from the load and advance inputs. From that record it checks, on every cycle, when the bus may be driven. The bus must be driven after a selected read, stay quiet after a write or a deselected command, stay quiet whenever the output enable is high, and read all zeros while undriven. The data values depend on stored contents. These are burst wrap order, per-lane merging, forwarding between back-to-back operations, and the proof that ignored chip-select and read/write inputs leave memory untouched. The bench shows them through a full write and read-back sweep of a small array, compared with a reference memory in the bench.

// File: rtl/psram_pkg.sv
package psram_pkg;
   localparam int BEAT_W = 2;

   typedef enum logic {
      DIR_WR = 1'b0,
      DIR_RD = 1'b1
   } dir_t;

   function automatic logic [BEAT_W-1:0] next_beat(input logic [BEAT_W-1:0] b);
      return b + 1'b1;
   endfunction
endpackage

// File: rtl/psram_cmd.sv
module psram_cmd
   import psram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_n,
   input  logic              rw,
   input  logic              cs_a_n,
   input  logic              cs_b_n,
   input  logic              cs_c,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  bwe_n,
   output logic              s1_sel,
   output dir_t              s1_dir,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [LANES-1:0]  s1_bwe_n
);
   localparam int UP_W = ADDR_W - BEAT_W;

   logic              sel_q;
   dir_t              dir_q;
   logic [UP_W-1:0]   up_q;
   logic [BEAT_W-1:0] beat_q;
   logic [LANES-1:0]  bwe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         dir_q  <= DIR_RD;
         up_q   <= '0;
         beat_q <= '0;
         bwe_q  <= '1;
      end else begin
         bwe_q <= bwe_n;
         if (!ld_n) begin
            sel_q  <= !cs_a_n && !cs_b_n && cs_c;
            dir_q  <= rw ? DIR_RD : DIR_WR;
            up_q   <= addr[ADDR_W-1:BEAT_W];
            beat_q <= addr[BEAT_W-1:0];
         end else begin
            beat_q <= next_beat(beat_q);
         end
      end
   end

   assign s1_sel   = sel_q;
   assign s1_dir   = dir_q;
   assign s1_addr  = {up_q, beat_q};
   assign s1_bwe_n = bwe_q;
endmodule

// File: rtl/psram_lane.sv
module psram_lane #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] wdata,
   output logic [LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/psram_rdout.sv
module psram_rdout #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   logic              vld_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         data_q <= '0;
      end else begin
         vld_q <= load;
         if (load) data_q <= word;
      end
   end

   assign dout_en = vld_q && !oe_n;
   assign dout    = dout_en ? data_q : '0;
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
   import psram_pkg::*;
#(
   parameter  int ADDR_W = 8,
   parameter  int LANES  = 4,
   parameter  int LANE_W = 9,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_n,
   input  logic              rw,
   input  logic              cs_a_n,
   input  logic              cs_b_n,
   input  logic              cs_c,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  bwe_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   if (ADDR_W <= BEAT_W) begin : g_bad_addr
      $error("ADDR_W must exceed the beat counter width");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("LANE_W must be at least 1");
   end

   logic              s1_sel;
   dir_t              s1_dir;
   logic [ADDR_W-1:0] s1_addr;
   logic [LANES-1:0]  s1_bwe_n;

   logic              s2_sel;
   dir_t              s2_dir;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s2_bwe_n;

   logic [DATA_W-1:0] rd_word;
   logic [LANES-1:0]  lane_we;
   logic              s2_rd;

   psram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_n     (ld_n),
      .rw       (rw),
      .cs_a_n   (cs_a_n),
      .cs_b_n   (cs_b_n),
      .cs_c     (cs_c),
      .addr     (addr),
      .bwe_n    (bwe_n),
      .s1_sel   (s1_sel),
      .s1_dir   (s1_dir),
      .s1_addr  (s1_addr),
      .s1_bwe_n (s1_bwe_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_sel   <= 1'b0;
         s2_dir   <= DIR_RD;
         s2_addr  <= '0;
         s2_bwe_n <= '1;
      end else begin
         s2_sel   <= s1_sel;
         s2_dir   <= s1_dir;
         s2_addr  <= s1_addr;
         s2_bwe_n <= s1_bwe_n;
      end
   end

   assign s2_rd = s2_sel && (s2_dir == DIR_RD);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_we[g] = s2_sel && (s2_dir == DIR_WR) && !s2_bwe_n[g];

      psram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
         .clk   (clk),
         .wr_en (lane_we[g]),
         .addr  (s2_addr),
         .wdata (din[g*LANE_W +: LANE_W]),
         .rdata (rd_word[g*LANE_W +: LANE_W])
      );
   end

   psram_rdout #(.DATA_W(DATA_W)) u_rdout (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (s2_rd),
      .word    (rd_word),
      .oe_n    (oe_n),
      .dout    (dout),
      .dout_en (dout_en)
   );
endmodule

// File: rtl/psram_chk.sv
module psram_chk #(
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_n,
   input logic              rw,
   input logic              cs_a_n,
   input logic              cs_b_n,
   input logic              cs_c,
   input logic              oe_n,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en
);
   logic c_sel, c_rd, rd1, rd2, wr1, wr2;
   logic cur_sel, cur_rd;

   always_comb begin
      cur_sel = ld_n ? c_sel : (!cs_a_n && !cs_b_n && cs_c);
      cur_rd  = ld_n ? c_rd  : rw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_sel <= 1'b0;
         c_rd  <= 1'b0;
         rd1   <= 1'b0;
         rd2   <= 1'b0;
         wr1   <= 1'b0;
         wr2   <= 1'b0;
      end else begin
         c_sel <= cur_sel;
         c_rd  <= cur_rd;
         rd1   <= cur_sel && cur_rd;
         rd2   <= rd1;
         wr1   <= cur_sel && !cur_rd;
         wr2   <= wr1;
      end
   end

   AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> (dout == '0)); // R1

   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      rd2 |=> (oe_n || dout_en)); // R2

   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      wr2 |=> !dout_en); // R3

   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd2 |=> !dout_en); // R6

   AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_en); // R8
endmodule

bind pipe_burst_sram psram_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ld_n    (ld_n),
   .rw      (rw),
   .cs_a_n  (cs_a_n),
   .cs_b_n  (cs_b_n),
   .cs_c    (cs_c),
   .oe_n    (oe_n),
   .dout    (dout),
   .dout_en (dout_en)
);

// File: tb/sim_pipe_burst_sram.sv
`timescale 1ns/1ps
module sim_pipe_burst_sram;
   localparam int AW = 5;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;
   localparam int DEPTH = 1 << AW;
   localparam logic [2:0] SEL = 3'b001; // {cs_a_n, cs_b_n, cs_c}

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_n = 1'b0, rw = 1'b1, cs_a_n = 1'b1, cs_b_n = 1'b1, cs_c = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [NL-1:0] bwe_n = '1;
   logic          oe_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   always #5 clk = ~clk;

   pipe_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .cs_a_n(cs_a_n),
      .cs_b_n(cs_b_n), .cs_c(cs_c), .addr(addr), .bwe_n(bwe_n),
      .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en));

   int n_chk = 0, n_bad = 0, cycno = 0;
   logic [DW-1:0] mem_m [DEPTH];

   // reference burst state
   logic          m_sel = 1'b0, m_rd = 1'b0;
   logic [AW-3:0] m_up = '0;
   logic [1:0]    m_cnt = '0;

   // reference pipeline
   logic          p1_sel = 0, p1_rd = 0, p2_sel = 0, p2_rd = 0;
   logic [AW-1:0] p1_a = '0, p2_a = '0;
   logic [NL-1:0] p1_be = '1, p2_be = '1;
   logic [DW-1:0] p1_w = '0, p2_w = '0;
   string         p1_tag = "R1", p2_tag = "R1", tag_q = "R1";
   logic          exp_chk = 0, exp_rd = 0;
   logic [DW-1:0] exp_d = '0;

   function automatic logic [DW-1:0] wd(input int n);
      return {4'(n * 3 + 1), 32'(n * 32'd2654435 + 32'd12345)};
   endfunction

   task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
      end
   endtask

   task automatic chk_word(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s dout act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic l, input logic r, input logic [2:0] cs,
                      input logic [AW-1:0] a, input logic [NL-1:0] be, input string tag);
      @(negedge clk);
      if (exp_chk) begin
         chk_bit(tag_q, "dout_en", dout_en, exp_rd && !oe_n);
         if (exp_rd && !oe_n) chk_word(tag_q, dout, exp_d);
         else chk_word("R1", dout, '0);
      end
      // command issued two cycles ago executes at the coming edge
      if (p2_sel && !p2_rd) begin
         for (int i = 0; i < NL; i++)
            if (!p2_be[i]) mem_m[p2_a][i*LW +: LW] = p2_w[i*LW +: LW];
         din = p2_w;
      end else begin
         din = ~wd(cycno);
      end
      exp_chk = 1'b1;
      exp_rd  = p2_sel && p2_rd;
      exp_d   = mem_m[p2_a];
      tag_q   = p2_tag;
      p2_sel = p1_sel; p2_rd = p1_rd; p2_a = p1_a; p2_be = p1_be; p2_w = p1_w; p2_tag = p1_tag;
      if (!l) begin
         m_sel = (cs == SEL);
         m_rd  = r;
         m_up  = a[AW-1:2];
         m_cnt = a[1:0];
      end else begin
         m_cnt = m_cnt + 2'd1;
      end
      p1_sel = m_sel; p1_rd = m_rd; p1_a = {m_up, m_cnt}; p1_be = be;
      p1_w = wd(cycno); p1_tag = tag;
      ld_n = l; rw = r; {cs_a_n, cs_b_n, cs_c} = cs; addr = a; bwe_n = be;
      cycno++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 3'b100, '0, '1, "R6");
   endtask

   logic done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      chk_bit("R1", "reset dout_en", dout_en, 1'b0);
      chk_word("R1", dout, '0);
      rst_n = 1'b1;
      idle(2);

      // R4/R5: write bursts, wrapping start beats, junk addr and toggling rw on advances
      for (int b = 0; b < DEPTH / 4; b++) begin
         cyc(1'b0, 1'b0, SEL, {3'(b), 2'(b)}, 4'h0, "R4");
         for (int k = 1; k < 4; k++)
            cyc(1'b1, 1'(k % 2), 3'(k * 2), 5'(b * 7 + k), 4'h0, "R5");
      end
      // R2/R4: read-back bursts, different start beat, rw low on advances
      for (int b = 0; b < DEPTH / 4; b++) begin
         cyc(1'b0, 1'b1, SEL, {3'(b), 2'(b + 1)}, 4'hF, "R2");
         for (int k = 1; k < 4; k++)
            cyc(1'b1, 1'b0, 3'b110, 5'(b * 3 + k), 4'hF, "R4");
      end
      idle(3);

      // R7: partial lane writes, every enable pattern
      for (int w = 0; w < DEPTH; w++)
         cyc(1'b0, 1'b0, SEL, 5'(w), 4'(w), "R7");
      for (int w = 0; w < DEPTH; w++)
         cyc(1'b0, 1'b1, SEL, 5'(w), 4'hF, "R7");
      idle(3);

      // R9/R3: write then read the same word on the next cycle, alternating
      for (int w = 0; w < 16; w++) begin
         cyc(1'b0, 1'b0, SEL, 5'(w * 2), 4'(w * 5), "R3");
         cyc(1'b0, 1'b1, SEL, 5'(w * 2), 4'hF, "R9");
      end
      idle(3);

      // R6/R10: every bad chip-select combination, then advances with good selects
      for (int c = 0; c < 8; c++) begin
         if (3'(c) != SEL) begin
            cyc(1'b0, 1'b0, 3'(c), 5'(4), 4'h0, "R6");
            for (int k = 1; k < 4; k++) cyc(1'b1, 1'b0, SEL, '0, 4'h0, "R10");
            cyc(1'b0, 1'b1, 3'(c), 5'(4), 4'hF, "R6");
            for (int k = 1; k < 4; k++) cyc(1'b1, 1'b1, SEL, '0, 4'hF, "R10");
         end
      end
      for (int w = 4; w < 8; w++) cyc(1'b0, 1'b1, SEL, 5'(w), 4'hF, "R6");
      idle(3);

      // R8: asynchronous output enable inside the driven cycle
      cyc(1'b0, 1'b1, SEL, 5'(9), 4'hF, "R8");
      idle(2);
      @(posedge clk);
      #2;
      oe_n = 1'b1;
      #1;
      chk_bit("R8", "oe high dout_en", dout_en, 1'b0);
      chk_word("R8", dout, '0);
      oe_n = 1'b0;
      #1;
      chk_bit("R8", "oe low dout_en", dout_en, 1'b1);
      chk_word("R8", dout, mem_m[9]);
      oe_n = 1'b1;
      idle(4);
      oe_n = 1'b0;
      idle(3);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule